// File: doc/BRIEF.md
# Redundant Row Majority Vote Decoder

This block sits on the read path of a one-time-programmable array. That array stores critical values as several copies, so that a few failed or flipped fuses do not corrupt the value. A client issues a read request that carries a mode and a base row address. The block then fetches one 24-bit row, or a run of consecutive rows, through a simple row-read interface. It rebuilds the value by voting bit by bit and returns the result with a one-cycle valid strobe.

There are four modes. Raw mode passes a single row through unchanged. Byte-triple mode finds three copies of one byte packed into one row. Triple-row mode spreads three copies of a 24-bit value over three rows. Octal-row mode spreads eight copies over eight rows. The vote threshold depends on the mode. The block also raises a mismatch flag whenever the copies disagree at any bit position, so software can notice fuse decay early while still receiving the voted value.

Top module: `otp_vote_decoder`

## Requirements
- R1: While rst_ni is low, and after it rises, busy_o, row_rd_o and res_valid_o are 0. A reset in the middle of a request abandons that request.
- R2: Mode encoding on req_mode_i is 0 = raw, 1 = byte-triple, 2 = triple-row, 3 = octal-row. In raw mode (0) one row is read at the base address and returned unchanged on res_data_o.
- R3: In byte-triple mode (1) one row is read. Its copies are bits [7:0], [15:8] and [23:16]. Each result bit k in [7:0] is 1 when at least two of the three copies have bit k set. Bits [23:8] of the result are 0.
- R4: In triple-row mode (2) rows base, base+1 and base+2 are read in that order. Each result bit is 1 when at least two of the three rows have it set.
- R5: In octal-row mode (3) rows base through base+7 are read in order. Each result bit is 1 when three or more of the eight rows have it set.
- R6: res_valid_o is a single-cycle pulse. It rises in the cycle after the cycle in which the last needed row is presented on row_valid_i.
- R7: A request on req_valid_i is accepted only while busy_o is 0. busy_o is 1 from the cycle after acceptance through the cycle of the valid strobe. A request presented while busy is ignored.
- R8: res_mismatch_o, valid with res_valid_o, is 1 when at least one bit position has copies that are not all equal. In byte-triple mode the copies are the three slices of the row; in the multi-row modes they are the rows. In raw mode it is 0.
- R9: row_rd_o is a one-cycle pulse and at most one row read is outstanding. The block issues exactly 1, 1, 3 or 8 reads for modes 0 to 3. A row_valid_i pulse arriving when no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request strobe |
| req_mode_i | input | 2 | Decode mode (0 raw, 1 byte-triple, 2 triple-row, 3 octal-row) |
| req_addr_i | input | ADDR_W | Base row address |
| busy_o | output | 1 | Request in progress |
| row_rd_o | output | 1 | Row read request pulse |
| row_addr_o | output | ADDR_W | Row address for the current read |
| row_valid_i | input | 1 | Row data returned |
| row_data_i | input | ROW_W | Returned row contents |
| res_valid_o | output | 1 | Decoded result strobe |
| res_data_o | output | ROW_W | Decoded value |
| res_mismatch_o | output | 1 | Copies disagreed at one or more bit positions |

## Verification
A stale per-bit counter or a wrong row index never hangs the block. It shows up as a wrong voted bit or a wrong mismatch flag in the very strobe of the affected request, which is why the vectors place copies exactly at the 2-of-3 and 3-of-8 thresholds and one below them. A control fault shows up at the ports within a few cycles. A miscounted row budget or address step appears as a wrong number of read pulses, or as a strobe that does not follow the last row by one cycle. A request that is not locked out while busy shows up as an extra read sequence or a corrupted result.

// File: rtl/otp_vote_pkg.sv
package otp_vote_pkg;
  typedef enum logic [1:0] {
    MODE_RAW    = 2'd0,
    MODE_BYTE3  = 2'd1,
    MODE_TRIPLE = 2'd2,
    MODE_OCTAL  = 2'd3
  } vote_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } vote_state_e;
endpackage

// File: rtl/otp_vote_ctrl.sv
module otp_vote_ctrl
  import otp_vote_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int TRI_COPIES = 3,
  parameter int OCT_COPIES = 8,
  localparam int LEFT_W    = $clog2(OCT_COPIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              row_valid_i,
  output logic              start_o,
  output logic              take_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              row_rd_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output vote_mode_e        mode_o
);
  vote_state_e       st_q, st_d;
  vote_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEFT_W-1:0] left_q, left_init;

  always_comb begin
    unique case (vote_mode_e'(req_mode_i))
      MODE_TRIPLE: left_init = LEFT_W'(TRI_COPIES - 1);
      MODE_OCTAL:  left_init = LEFT_W'(OCT_COPIES - 1);
      default:     left_init = '0;
    endcase
  end

  assign start_o = (st_q == ST_IDLE) && req_valid_i;
  assign take_o  = (st_q == ST_WAIT) && row_valid_i;
  assign last_o  = take_o && (left_q == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (row_valid_i) st_d = (left_q == '0) ? ST_DONE : ST_ISSUE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_RAW;
      addr_q <= '0;
      left_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        mode_q <= vote_mode_e'(req_mode_i);
        addr_q <= req_addr_i;
        left_q <= left_init;
      end else if (take_o && !last_o) begin
        addr_q <= addr_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign row_rd_o   = (st_q == ST_ISSUE);
  assign row_addr_o = addr_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign mode_o     = mode_q;
endmodule

// File: rtl/otp_vote_accum.sv
module otp_vote_accum #(
  parameter int ROW_W      = 24,
  parameter int OCT_COPIES = 8,
  localparam int CNT_W     = $clog2(OCT_COPIES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        take_i,
  input  logic [ROW_W-1:0]            row_i,
  output logic [ROW_W-1:0][CNT_W-1:0] cnt_nxt_o,
  output logic [ROW_W-1:0]            any1_nxt_o,
  output logic [ROW_W-1:0]            any0_nxt_o
);
  logic [ROW_W-1:0] any1_q, any0_q;

  for (genvar b = 0; b < ROW_W; b++) begin : g_bit
    logic [CNT_W-1:0] cnt_q;
    assign cnt_nxt_o[b] = cnt_q + CNT_W'(row_i[b]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (take_i) cnt_q <= cnt_nxt_o[b];
    end
  end

  assign any1_nxt_o = any1_q | row_i;
  assign any0_nxt_o = any0_q | ~row_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any1_q <= '0;
      any0_q <= '0;
    end else if (clr_i) begin
      any1_q <= '0;
      any0_q <= '0;
    end else if (take_i) begin
      any1_q <= any1_nxt_o;
      any0_q <= any0_nxt_o;
    end
  end
endmodule

// File: rtl/otp_vote_byte3.sv
module otp_vote_byte3 #(
  parameter int BYTE_W = 8,
  localparam int ROW_W = 3 * BYTE_W
) (
  input  logic [ROW_W-1:0]  row_i,
  output logic [BYTE_W-1:0] vote_o,
  output logic              mismatch_o
);
  logic [BYTE_W-1:0] c0, c1, c2;
  assign c0 = row_i[BYTE_W-1:0];
  assign c1 = row_i[2*BYTE_W-1:BYTE_W];
  assign c2 = row_i[3*BYTE_W-1:2*BYTE_W];

  assign vote_o     = (c0 & c1) | (c0 & c2) | (c1 & c2);
  assign mismatch_o = |((c0 ^ c1) | (c0 ^ c2));
endmodule

// File: rtl/otp_vote_decoder.sv
module otp_vote_decoder
  import otp_vote_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BYTE_W     = 8,
  parameter int TRI_COPIES = 3,
  parameter int OCT_COPIES = 8,
  parameter int TRI_THRESH = 2,
  parameter int OCT_THRESH = 3,
  localparam int ROW_W     = 3 * BYTE_W,
  localparam int CNT_W     = $clog2(OCT_COPIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic              row_rd_o,
  output logic [ADDR_W-1:0] row_addr_o,
  input  logic              row_valid_i,
  input  logic [ROW_W-1:0]  row_data_i,
  output logic              res_valid_o,
  output logic [ROW_W-1:0]  res_data_o,
  output logic              res_mismatch_o
);
  logic                        start, take, last;
  vote_mode_e                  mode;
  logic [ROW_W-1:0][CNT_W-1:0] cnt_nxt;
  logic [ROW_W-1:0]            any1_nxt, any0_nxt, vote_vec;
  logic [BYTE_W-1:0]           byte_vote;
  logic                        byte_mis;
  logic [CNT_W-1:0]            thresh;
  logic [ROW_W-1:0]            res_q;
  logic                        mis_q;

  otp_vote_ctrl #(
    .ADDR_W(ADDR_W), .TRI_COPIES(TRI_COPIES), .OCT_COPIES(OCT_COPIES)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_mode_i, .req_addr_i, .row_valid_i,
    .start_o(start), .take_o(take), .last_o(last), .busy_o,
    .done_o(res_valid_o), .row_rd_o, .row_addr_o, .mode_o(mode)
  );

  otp_vote_accum #(.ROW_W(ROW_W), .OCT_COPIES(OCT_COPIES)) u_accum (
    .clk_i, .rst_ni, .clr_i(start), .take_i(take), .row_i(row_data_i),
    .cnt_nxt_o(cnt_nxt), .any1_nxt_o(any1_nxt), .any0_nxt_o(any0_nxt)
  );

  otp_vote_byte3 #(.BYTE_W(BYTE_W)) u_byte3 (
    .row_i(row_data_i), .vote_o(byte_vote), .mismatch_o(byte_mis)
  );

  assign thresh = (mode == MODE_OCTAL) ? CNT_W'(OCT_THRESH) : CNT_W'(TRI_THRESH);

  for (genvar b = 0; b < ROW_W; b++) begin : g_vote
    assign vote_vec[b] = (cnt_nxt[b] >= thresh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      mis_q <= 1'b0;
    end else if (last) begin
      unique case (mode)
        MODE_RAW: begin
          res_q <= row_data_i;
          mis_q <= 1'b0;
        end
        MODE_BYTE3: begin
          res_q <= ROW_W'(byte_vote);
          mis_q <= byte_mis;
        end
        default: begin
          res_q <= vote_vec;
          mis_q <= |(any1_nxt & any0_nxt);
        end
      endcase
    end
  end

  assign res_data_o     = res_q;
  assign res_mismatch_o = mis_q;
endmodule

// File: rtl/otp_vote_checker.sv
module otp_vote_checker #(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  localparam int ROW_W = 3 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_mode_i,
  input logic              busy_o,
  input logic              row_rd_o,
  input logic [ADDR_W-1:0] row_addr_o,
  input logic              res_valid_o,
  input logic [ROW_W-1:0]  res_data_o,
  input logic              res_mismatch_o
);
  logic [ADDR_W-1:0] last_addr;
  logic              have_last;
  logic [1:0]        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr <= '0;
      have_last <= 1'b0;
      mode_q    <= 2'd0;
    end else begin
      if (!busy_o && req_valid_i) mode_q <= req_mode_i;
      if (res_valid_o) have_last <= 1'b0;
      else if (row_rd_o) begin
        have_last <= 1'b1;
        last_addr <= row_addr_o;
      end
    end
  end

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  assert_valid_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> busy_o);
  assert_accept_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> busy_o);
  assert_rd_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_rd_o |=> !row_rd_o);
  assert_rd_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_rd_o |-> busy_o);
  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_rd_o && have_last) |-> (row_addr_o == last_addr + 1'b1));
  assert_byte_zext_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && mode_q == 2'd1) |-> ((res_data_o >> BYTE_W) == '0));
  assert_raw_nomis_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && mode_q == 2'd0) |-> !res_mismatch_o);
endmodule

bind otp_vote_decoder otp_vote_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_mode_i(req_mode_i),
  .busy_o(busy_o), .row_rd_o(row_rd_o), .row_addr_o(row_addr_o),
  .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_mismatch_o(res_mismatch_o)
);

// File: tb/sim_otp_vote_decoder.sv
module sim_otp_vote_decoder;
  localparam int ADDR_W = 12;
  localparam int ROW_W  = 24;
  localparam int NVEC   = 8;

  typedef struct packed {
    logic [1:0]            mode;
    logic [5:0]            base;
    logic [7:0][ROW_W-1:0] rows;
    logic [ROW_W-1:0]      exp;
    logic                  mis;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 6'd5,  {{7{24'h0}}, 24'hA5C30F}, 24'hA5C30F, 1'b0},
    '{2'd1, 6'd9,  {{7{24'h0}}, 24'h5A5A5A}, 24'h00005A, 1'b0},
    '{2'd1, 6'd12, {{7{24'h0}}, 24'hF0FF0F}, 24'h0000FF, 1'b1},
    '{2'd2, 6'd20, {{5{24'h0}}, {3{24'h123456}}}, 24'h123456, 1'b0},
    '{2'd2, 6'd24, {{5{24'h0}}, 24'hF0F0F0, 24'h00FFFF, 24'hFFFF00}, 24'hF0FFF0, 1'b1},
    '{2'd3, 6'd40, {8{24'hC3C3C3}}, 24'hC3C3C3, 1'b0},
    '{2'd3, 6'd48, {{5{24'h800000}}, 24'h000001, 24'h000003, 24'h000003}, 24'h800001, 1'b1},
    '{2'd3, 6'd56, {{3{24'h000110}}, {5{24'h000010}}}, 24'h000110, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_mode = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              busy, row_rd, res_valid, res_mis;
  logic [ADDR_W-1:0] row_addr;
  logic [ROW_W-1:0]  res_data, row_data, mem_rd = '0;
  logic              row_valid, mem_rv = 1'b0, stray = 1'b0;
  logic [ROW_W-1:0]  mem [64];
  int                rd_cnt = 0;
  int                total = 0, bad = 0;

  always #5 clk = ~clk;

  assign row_valid = mem_rv | stray;
  assign row_data  = stray ? 24'hFFFFFF : mem_rd;

  always @(posedge clk) begin
    if (!rst_n) mem_rv <= 1'b0;
    else begin
      mem_rv <= row_rd;
      if (row_rd) begin
        mem_rd <= mem[row_addr[5:0]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  otp_vote_decoder #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .req_addr_i(req_addr), .busy_o(busy), .row_rd_o(row_rd), .row_addr_o(row_addr),
    .row_valid_i(row_valid), .row_data_i(row_data), .res_valid_o(res_valid),
    .res_data_o(res_data), .res_mismatch_o(res_mis)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    for (int r = 0; r < 8; r++) mem[v.base + r] = v.rows[r];
  endtask

  task automatic issue(input logic [1:0] m, input logic [5:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int nreads(input logic [1:0] m);
    return (m == 2'd3) ? 8 : (m == 2'd2) ? 3 : 1;
  endfunction

  // waits for the strobe, then checks value, flag, read count, timing and release
  task automatic collect(input logic [1:0] m, input logic [23:0] exp, input logic exp_mis,
                         input int rd0, input string tag);
    bit prev_rv = 1'b0;
    bit seen = 1'b0;
    for (int c = 0; c < 200 && !seen; c++) begin
      if (res_valid) seen = 1'b1;
      else begin
        prev_rv = row_valid;
        @(negedge clk);
      end
    end
    chk(seen, {tag, " strobe seen R6"}, 32'(seen), 32'd1);
    chk(res_data == exp, tag, 32'(res_data), 32'(exp));
    chk(res_mis == exp_mis, {tag, " mismatch R8"}, 32'(res_mis), 32'(exp_mis));
    chk(rd_cnt - rd0 == nreads(m), {tag, " read count R9"}, 32'(rd_cnt - rd0), 32'(nreads(m)));
    chk(prev_rv, {tag, " strobe one cycle after last row R6"}, 32'(prev_rv), 32'd1);
    chk(busy, {tag, " busy at strobe R7"}, 32'(busy), 32'd1);
    @(negedge clk);
    chk(!res_valid && !busy, {tag, " strobe single pulse, busy released R6 R7"},
        32'({res_valid, busy}), 32'd0);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2 raw";
      2'd1: return "R3 byte-triple";
      2'd2: return "R4 triple-row";
      default: return "R5 octal-row";
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rd0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !row_rd && !res_valid, "R1 outputs in reset", 32'({busy, row_rd, res_valid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !row_rd && !res_valid, "R1 outputs after reset", 32'({busy, row_rd, res_valid}), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      load(VECS[v]);
      rd0 = rd_cnt;
      issue(VECS[v].mode, VECS[v].base);
      collect(VECS[v].mode, VECS[v].exp, VECS[v].mis, rd0, mode_tag(VECS[v].mode));
    end

    // R7: request while busy is ignored
    load(VECS[5]);
    load(VECS[0]);
    rd0 = rd_cnt;
    issue(2'd3, 6'd40);
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd0; req_addr = ADDR_W'(5);
    @(negedge clk);
    req_valid = 1'b0;
    collect(2'd3, 24'hC3C3C3, 1'b0, rd0, "R7 request while busy ignored");

    // R9: stray row_valid while idle
    @(negedge clk);
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!res_valid && !busy && !row_rd, "R9 stray row ignored while idle",
          32'({res_valid, busy, row_rd}), 32'd0);
    end
    rd0 = rd_cnt;
    issue(2'd0, 6'd5);
    collect(2'd0, 24'hA5C30F, 1'b0, rd0, "R9 raw after stray");

    // R1: reset mid-request
    issue(2'd3, 6'd40);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !row_rd && !res_valid, "R1 mid-request reset", 32'({busy, row_rd, res_valid}), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid, "R1 request abandoned", 32'({busy, res_valid}), 32'd0);
    rd0 = rd_cnt;
    issue(2'd1, 6'd12);
    load(VECS[2]);
    collect(2'd1, 24'h0000FF, 1'b1, rd0, "R3 byte-triple after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule